// File: doc/BRIEF.md
# Split Read Reassembly Tracker

This block sits on the requester side of a packet link that issues memory reads and receives the data as tagged completions. Each read accepted on the request port gets the lowest-numbered free tag. The block loads that tag's remaining byte count and write offset, and it pushes the tag into an issue-order ring. Completions come in on a separate port. Each one is a header carrying a tag and a payload byte count, followed by that many bytes as 32-bit data beats. The tag is the only thing used to find the matching read. Pieces of one read arrive in increasing address order, so a per-tag running word offset places each beat in that tag's slot of a shared buffer. Pieces of different reads may interleave in any mix. The header port is ready whenever no payload is in progress.

A completion FSM has three states. `C_IDLE` waits for a header. `C_FILL` writes the announced number of beats into the tag's slot. `C_DROP` swallows the beats of a rejected completion. Its transitions are: `C_IDLE -> C_FILL` on a valid header, `C_IDLE -> C_DROP` on a rejected header that announces at least one beat, and `C_FILL/C_DROP -> C_IDLE` on the last announced beat. A rejected header with fewer than one beat stays in `C_IDLE`.

A retirement FSM has two states. `R_WAIT` looks at the oldest outstanding read. `R_SEND` streams that read's words. Its transitions are: `R_WAIT -> R_SEND` once the oldest read has zero bytes remaining, and `R_SEND -> R_WAIT` when its last word is accepted. That last transfer frees the tag and pops the ring.

Top module: `rdtrk_top`

## Requirements
- R1: After reset, `req_ready` and `cpl_hdr_ready` are 1, and `out_valid` and `cpl_err` are 0.
- R2: An accepted request (`req_valid && req_ready`) takes the lowest-numbered free tag, shown on `req_tag` in the cycle of acceptance. `req_ready` is 0 while all NTAG tags are held.
- R3: A tag stays held after all its bytes have arrived. It is released only when the last word of its read is accepted on the output, and a later request may then receive it again.
- R4: A completion is matched to its read by tag alone. Its data beats land at consecutive word offsets, continuing from the words already received for that tag.
- R5: A read of any length from 4 to SLOT_BYTES bytes (a multiple of 4) may be answered by any number of completions, each a nonzero multiple of 4 bytes, as long as they sum to the length.
- R6: Completions for different tags may interleave in any order. `cpl_hdr_ready` is 1 whenever no payload is in progress, including in the cycle right after the last beat of a completion.
- R7: Reads are delivered strictly in issue order. A read whose bytes have all arrived produces no output while any earlier-issued read is still undelivered.
- R8: A delivered read appears as len/4 words in address order on `out_data`. `out_tag` carries its tag on every word, and `out_last` is 1 on the final word only.
- R9: A header whose tag is not held makes `cpl_err` high for exactly one cycle, the cycle after the header is taken. The next floor(bytes/4) data beats are discarded.
- R10: A header for a held tag whose byte count is 0, is not a multiple of 4, or exceeds the bytes still outstanding for that tag is handled like R9. Its beats are discarded, and that tag's offset and remaining count are left unchanged.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_tag`, `out_last` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | New read request |
| req_len | input | $clog2(SLOT_BYTES)+1 | Read length in bytes |
| req_ready | output | 1 | A tag is free |
| req_tag | output | $clog2(NTAG) | Tag given to the request being accepted |
| cpl_hdr_valid | input | 1 | Completion header present |
| cpl_hdr_tag | input | $clog2(NTAG) | Tag of the read being answered |
| cpl_hdr_bytes | input | $clog2(SLOT_BYTES)+1 | Payload bytes in this completion |
| cpl_hdr_ready | output | 1 | Header accepted this cycle if valid |
| cpl_dat_valid | input | 1 | Completion data beat present |
| cpl_dat | input | 32 | Completion data beat |
| cpl_err | output | 1 | One-cycle pulse for a rejected header |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Reassembled read data word |
| out_last | output | 1 | Final word of the read |
| out_tag | output | $clog2(NTAG) | Tag of the read being delivered |

## Verification
The bench builds the block with NTAG=4 and SLOT_BYTES=64. At that size, exhausting the tag pool and reusing a freed tag take only a few requests. The same small size makes a full sweep of every legal read length possible, each split into several completion sizes from single-word pieces up to one whole piece. Completion interleavings are built by hand on top of that. One has every later read finished while the oldest is still open. Another reuses a tag freed in the middle of a batch. A third mixes each class of rejected header between good pieces of the same read. Output backpressure toggles from run to run, so hold behaviour is exercised on reads of every length.

// File: rtl/rdtrk_pkg.sv
package rdtrk_pkg;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_FILL = 2'd1,
        C_DROP = 2'd2
    } cpl_state_t;

    typedef enum logic {
        R_WAIT = 1'b0,
        R_SEND = 1'b1
    } ret_state_t;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;

endpackage

// File: rtl/rdtrk_tag_pool.sv
module rdtrk_tag_pool #(
    parameter int unsigned NTAG = 8,
    localparam int unsigned TAGW = $clog2(NTAG),
    localparam int unsigned CNTW = TAGW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_fire,
    input  logic            retire,
    output logic            alloc_ok,
    output logic [TAGW-1:0] alloc_tag,
    output logic [NTAG-1:0] held,
    output logic            head_valid,
    output logic [TAGW-1:0] head_tag
);

    logic [NTAG-1:0] held_q, held_d;
    logic [TAGW-1:0] ring_q [NTAG];
    logic [TAGW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNTW-1:0] cnt_q;

    // lowest-numbered free tag
    always_comb begin
        alloc_ok  = 1'b0;
        alloc_tag = '0;
        for (int i = 0; i < NTAG; i++) begin
            if (!held_q[i] && !alloc_ok) begin
                alloc_tag = TAGW'(i);
                alloc_ok  = 1'b1;
            end
        end
    end

    assign head_tag   = ring_q[rd_ptr_q];
    assign head_valid = (cnt_q != '0);
    assign held       = held_q;

    always_comb begin
        held_d = held_q;
        if (alloc_fire) held_d[alloc_tag] = 1'b1;
        if (retire)     held_d[head_tag]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q   <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            for (int i = 0; i < NTAG; i++) ring_q[i] <= '0;
        end else begin
            held_q <= held_d;
            if (alloc_fire) begin
                ring_q[wr_ptr_q] <= alloc_tag;
                wr_ptr_q         <= wr_ptr_q + TAGW'(1);
            end
            if (retire) rd_ptr_q <= rd_ptr_q + TAGW'(1);
            if (alloc_fire && !retire)      cnt_q <= cnt_q + CNTW'(1);
            else if (!alloc_fire && retire) cnt_q <= cnt_q - CNTW'(1);
        end
    end

    a_r2_alloc_marks_held: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> held_q[$past(alloc_tag)]);

    a_r2_ring_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> (cnt_q < CNTW'(NTAG)));

    a_r3_retire_releases: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !held_q[$past(head_tag)]);

    a_r3_retire_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> head_valid);

endmodule

// File: rtl/rdtrk_tag_table.sv
module rdtrk_tag_table #(
    parameter int unsigned NTAG       = 8,
    parameter int unsigned SLOT_BYTES = 256,
    localparam int unsigned TAGW       = $clog2(NTAG),
    localparam int unsigned SLOT_WORDS = SLOT_BYTES / rdtrk_pkg::WORD_BYTES,
    localparam int unsigned WIDXW      = $clog2(SLOT_WORDS),
    localparam int unsigned LENW       = $clog2(SLOT_BYTES) + 1,
    localparam int unsigned DEPTH      = NTAG * SLOT_WORDS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_fire,
    input  logic [TAGW-1:0]               alloc_tag,
    input  logic [LENW-1:0]               alloc_len,
    input  logic                          beat_en,
    input  logic [TAGW-1:0]               beat_tag,
    input  logic [rdtrk_pkg::WORD_W-1:0]  beat_data,
    input  logic [TAGW-1:0]               chk_tag,
    output logic [LENW-1:0]               chk_rem,
    input  logic [TAGW-1:0]               rd_tag,
    input  logic [WIDXW-1:0]              rd_idx,
    output logic [LENW-1:0]               rd_rem,
    output logic [LENW-1:0]               rd_words,
    output logic [rdtrk_pkg::WORD_W-1:0]  rd_data
);

    logic [LENW-1:0]              rem_q  [NTAG];
    logic [LENW-1:0]              len_q  [NTAG];
    logic [WIDXW-1:0]             wofs_q [NTAG];
    logic [rdtrk_pkg::WORD_W-1:0] buf_q  [DEPTH];

    logic [TAGW+WIDXW-1:0] waddr, raddr;

    assign waddr    = {beat_tag, wofs_q[beat_tag]};
    assign raddr    = {rd_tag, rd_idx};
    assign chk_rem  = rem_q[chk_tag];
    assign rd_rem   = rem_q[rd_tag];
    assign rd_words = len_q[rd_tag] >> 2;
    assign rd_data  = buf_q[raddr];

    always_ff @(posedge clk) begin
        if (beat_en) buf_q[waddr] <= beat_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAG; i++) begin
                rem_q[i]  <= '0;
                len_q[i]  <= '0;
                wofs_q[i] <= '0;
            end
        end else begin
            if (alloc_fire) begin
                rem_q[alloc_tag]  <= alloc_len;
                len_q[alloc_tag]  <= alloc_len;
                wofs_q[alloc_tag] <= '0;
            end
            if (beat_en) begin
                rem_q[beat_tag]  <= rem_q[beat_tag] - LENW'(rdtrk_pkg::WORD_BYTES);
                wofs_q[beat_tag] <= wofs_q[beat_tag] + WIDXW'(1);
            end
        end
    end

    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        beat_en |-> (rem_q[beat_tag] >= LENW'(rdtrk_pkg::WORD_BYTES)));

    a_r2_alloc_vs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && beat_en) |-> (alloc_tag != beat_tag));

endmodule

// File: rtl/rdtrk_cpl_fsm.sv
module rdtrk_cpl_fsm #(
    parameter int unsigned NTAG       = 8,
    parameter int unsigned SLOT_BYTES = 256,
    localparam int unsigned TAGW = $clog2(NTAG),
    localparam int unsigned LENW = $clog2(SLOT_BYTES) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hdr_valid,
    input  logic [TAGW-1:0] hdr_tag,
    input  logic [LENW-1:0] hdr_bytes,
    input  logic            dat_valid,
    input  logic [NTAG-1:0] held,
    input  logic [LENW-1:0] chk_rem,
    output logic            hdr_ready,
    output logic            beat_en,
    output logic [TAGW-1:0] beat_tag,
    output logic            err
);
    import rdtrk_pkg::*;

    cpl_state_t      state_q, state_d;
    logic [TAGW-1:0] tag_q;
    logic [LENW-1:0] left_q;
    logic            err_q;
    logic            hdr_take, hdr_ok, last_beat;
    logic [LENW-1:0] hdr_beats;

    assign hdr_take  = (state_q == C_IDLE) && hdr_valid;
    assign hdr_beats = hdr_bytes >> 2;
    assign hdr_ok    = held[hdr_tag] && (hdr_bytes != '0) &&
                       (hdr_bytes[1:0] == 2'b00) && (hdr_bytes <= chk_rem);
    assign last_beat = dat_valid && (left_q == LENW'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (hdr_take) begin
                    if (hdr_ok)                 state_d = C_FILL;
                    else if (hdr_beats != '0)   state_d = C_DROP;
                end
            end
            C_FILL:  if (last_beat) state_d = C_IDLE;
            C_DROP:  if (last_beat) state_d = C_IDLE;
            default: state_d = C_IDLE;
        endcase
    end

    // state register and beat bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
            tag_q   <= '0;
            left_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= hdr_take && !hdr_ok;
            if (hdr_take) begin
                tag_q  <= hdr_tag;
                left_q <= hdr_beats;
            end else if (state_q != C_IDLE && dat_valid) begin
                left_q <= left_q - LENW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        hdr_ready = (state_q == C_IDLE);
        beat_en   = (state_q == C_FILL) && dat_valid;
        beat_tag  = tag_q;
        err       = err_q;
    end

    a_r9_err_follows_header: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(state_q == C_IDLE && hdr_valid));

    a_r4_fill_held_tag: assert property (@(posedge clk) disable iff (!rst_n)
        beat_en |-> held[beat_tag]);

    a_r6_payload_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != C_IDLE) |-> (left_q != '0));

endmodule

// File: rtl/rdtrk_retire_fsm.sv
module rdtrk_retire_fsm #(
    parameter int unsigned NTAG       = 8,
    parameter int unsigned SLOT_BYTES = 256,
    localparam int unsigned TAGW       = $clog2(NTAG),
    localparam int unsigned SLOT_WORDS = SLOT_BYTES / rdtrk_pkg::WORD_BYTES,
    localparam int unsigned WIDXW      = $clog2(SLOT_WORDS),
    localparam int unsigned LENW       = $clog2(SLOT_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [TAGW-1:0]  head_tag,
    input  logic [LENW-1:0]  head_rem,
    input  logic [LENW-1:0]  head_words,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic [TAGW-1:0]  out_tag,
    output logic [WIDXW-1:0] rd_idx,
    output logic             retire
);
    import rdtrk_pkg::*;

    ret_state_t       state_q, state_d;
    logic [WIDXW-1:0] idx_q;
    logic             at_last;

    assign at_last = ({{(LENW-WIDXW){1'b0}}, idx_q} + LENW'(1)) == head_words;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_WAIT:  if (head_valid && head_rem == '0) state_d = R_SEND;
            R_SEND:  if (out_ready && at_last)         state_d = R_WAIT;
            default: state_d = R_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= R_WAIT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == R_SEND && out_ready)
                idx_q <= at_last ? '0 : idx_q + WIDXW'(1);
        end
    end

    always_comb begin
        out_valid = (state_q == R_SEND);
        out_last  = (state_q == R_SEND) && at_last;
        out_tag   = head_tag;
        rd_idx    = idx_q;
        retire    = (state_q == R_SEND) && out_ready && at_last;
    end

    a_r7_send_only_complete: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (head_valid && head_rem == '0));

    a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx_q) && $stable(head_tag)));

    a_r8_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !out_valid);

endmodule

// File: rtl/rdtrk_top.sv
module rdtrk_top #(
    parameter int unsigned NTAG       = 8,
    parameter int unsigned SLOT_BYTES = 256,
    localparam int unsigned TAGW       = $clog2(NTAG),
    localparam int unsigned SLOT_WORDS = SLOT_BYTES / rdtrk_pkg::WORD_BYTES,
    localparam int unsigned WIDXW      = $clog2(SLOT_WORDS),
    localparam int unsigned LENW       = $clog2(SLOT_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LENW-1:0]  req_len,
    output logic             req_ready,
    output logic [TAGW-1:0]  req_tag,
    input  logic             cpl_hdr_valid,
    input  logic [TAGW-1:0]  cpl_hdr_tag,
    input  logic [LENW-1:0]  cpl_hdr_bytes,
    output logic             cpl_hdr_ready,
    input  logic             cpl_dat_valid,
    input  logic [31:0]      cpl_dat,
    output logic             cpl_err,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic             out_last,
    output logic [TAGW-1:0]  out_tag
);

    logic             alloc_fire, alloc_ok, retire, head_valid, beat_en;
    logic [TAGW-1:0]  alloc_tag, head_tag, beat_tag;
    logic [NTAG-1:0]  held;
    logic [LENW-1:0]  chk_rem, head_rem, head_words;
    logic [WIDXW-1:0] rd_idx;

    assign req_ready  = alloc_ok;
    assign req_tag    = alloc_tag;
    assign alloc_fire = req_valid && alloc_ok;

    rdtrk_tag_pool #(.NTAG(NTAG)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .retire     (retire),
        .alloc_ok   (alloc_ok),
        .alloc_tag  (alloc_tag),
        .held       (held),
        .head_valid (head_valid),
        .head_tag   (head_tag)
    );

    rdtrk_tag_table #(.NTAG(NTAG), .SLOT_BYTES(SLOT_BYTES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .alloc_tag  (alloc_tag),
        .alloc_len  (req_len),
        .beat_en    (beat_en),
        .beat_tag   (beat_tag),
        .beat_data  (cpl_dat),
        .chk_tag    (cpl_hdr_tag),
        .chk_rem    (chk_rem),
        .rd_tag     (head_tag),
        .rd_idx     (rd_idx),
        .rd_rem     (head_rem),
        .rd_words   (head_words),
        .rd_data    (out_data)
    );

    rdtrk_cpl_fsm #(.NTAG(NTAG), .SLOT_BYTES(SLOT_BYTES)) u_cpl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_valid  (cpl_hdr_valid),
        .hdr_tag    (cpl_hdr_tag),
        .hdr_bytes  (cpl_hdr_bytes),
        .dat_valid  (cpl_dat_valid),
        .held       (held),
        .chk_rem    (chk_rem),
        .hdr_ready  (cpl_hdr_ready),
        .beat_en    (beat_en),
        .beat_tag   (beat_tag),
        .err        (cpl_err)
    );

    rdtrk_retire_fsm #(.NTAG(NTAG), .SLOT_BYTES(SLOT_BYTES)) u_retire (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_valid (head_valid),
        .head_tag   (head_tag),
        .head_rem   (head_rem),
        .head_words (head_words),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_tag    (out_tag),
        .rd_idx     (rd_idx),
        .retire     (retire)
    );

    a_r1_quiet_err_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpl_err && !out_valid));

    a_r3_no_request_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (&held) |-> !req_ready);

endmodule

// File: tb/rdtrk_top_tb_top.sv
module rdtrk_top_tb_top;

    localparam int NT      = 4;
    localparam int SB      = 64;
    localparam int TW      = $clog2(NT);
    localparam int LW      = $clog2(SB) + 1;
    localparam int CLK_PER = 10;
    localparam int EMAX    = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready;
    logic [TW-1:0] req_tag;
    logic          cpl_hdr_valid = 1'b0;
    logic [TW-1:0] cpl_hdr_tag = '0;
    logic [LW-1:0] cpl_hdr_bytes = '0;
    logic          cpl_hdr_ready;
    logic          cpl_dat_valid = 1'b0;
    logic [31:0]   cpl_dat = '0;
    logic          cpl_err;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [31:0]   out_data;
    logic          out_last;
    logic [TW-1:0] out_tag;

    always #(CLK_PER/2) clk = ~clk;

    rdtrk_top #(.NTAG(NT), .SLOT_BYTES(SB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready), .req_tag(req_tag),
        .cpl_hdr_valid(cpl_hdr_valid), .cpl_hdr_tag(cpl_hdr_tag), .cpl_hdr_bytes(cpl_hdr_bytes),
        .cpl_hdr_ready(cpl_hdr_ready), .cpl_dat_valid(cpl_dat_valid), .cpl_dat(cpl_dat),
        .cpl_err(cpl_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .out_tag(out_tag)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_n = 0;
    int cap_n = 0;
    int id_ctr = 0;
    int err_seen = 0;
    int bp_mode = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] exp_d [EMAX];
    int          exp_t [EMAX];
    bit          exp_l [EMAX];
    int          tag_id [NT];
    bit          prev_stall = 1'b0;
    logic [31:0] prev_d = '0;
    logic [TW-1:0] prev_t = '0;
    logic        prev_l = 1'b0;

    function automatic logic [31:0] pat(int id, int w);
        return 32'hA5000000 + 32'(id) * 32'h00010000 + 32'(w) * 32'h00000011;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // output monitor: picks out_ready, then records the transfer of the coming edge
    always @(negedge clk) begin
        cyc++;
        out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
        if (rst_n) begin
            if (cpl_err) err_seen++;
            if (prev_stall)
                chk(out_valid && out_data == prev_d && out_tag == prev_t && out_last == prev_l,
                    "R11", "word held under stall", out_data, prev_d);
            if (out_valid && out_ready) begin
                if (cap_n >= exp_n) begin
                    chk(1'b0, "R7", "unexpected output word", out_data, 0);
                end else begin
                    chk(out_data == exp_d[cap_n], "R8", "data word", out_data, exp_d[cap_n]);
                    chk(int'(out_tag) == exp_t[cap_n], "R4", "out_tag", 32'(out_tag), exp_t[cap_n]);
                    chk(out_last == exp_l[cap_n], "R8", "out_last", 32'(out_last), 32'(exp_l[cap_n]));
                end
                cap_n++;
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_t = out_tag;
            prev_l = out_last;
        end
    end

    task automatic issue(int len, int etag, output int tag);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_len   = LW'(len);
        tag       = int'(req_tag);
        chk(tag == etag, "R2", "lowest free tag", 32'(tag), 32'(etag));
        tag_id[tag] = id_ctr;
        for (int w = 0; w < len / 4; w++) begin
            exp_d[exp_n] = pat(id_ctr, w);
            exp_t[exp_n] = tag;
            exp_l[exp_n] = (w == len / 4 - 1);
            exp_n++;
        end
        id_ctr++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_cpl(int tag, int bytes, int first_w, bit junk);
        while (!cpl_hdr_ready) @(negedge clk);
        cpl_hdr_valid = 1'b1;
        cpl_hdr_tag   = TW'(tag);
        cpl_hdr_bytes = LW'(bytes);
        @(negedge clk);
        cpl_hdr_valid = 1'b0;
        for (int k = 0; k < bytes / 4; k++) begin
            cpl_dat_valid = 1'b1;
            cpl_dat = junk ? (32'hDEAD0000 + 32'(k)) : pat(tag_id[tag], first_w + k);
            @(negedge clk);
        end
        cpl_dat_valid = 1'b0;
    endtask

    task automatic drain(string req);
        int guard = 0;
        while (cap_n < exp_n && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(cap_n == exp_n, req, "all words delivered", 32'(cap_n), 32'(exp_n));
        @(negedge clk);
    endtask

    initial begin
        int t0, t1, t2, t3, t4, base_cap, base_err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
        chk(cpl_hdr_ready == 1'b1, "R1", "cpl_hdr_ready after reset", 32'(cpl_hdr_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
        chk(cpl_err == 1'b0, "R1", "cpl_err after reset", 32'(cpl_err), 0);

        // R5/R8/R11: every length, several piece sizes, alternating backpressure
        for (int len = 4; len <= SB; len += 4) begin
            for (int pi = 0; pi < 5; pi++) begin
                int p, off;
                p = 4 << pi;
                if (pi > 0 && (4 << (pi - 1)) >= len) continue;
                bp_mode = (len / 4 + pi) % 2;
                issue(len, 0, t0);
                off = 0;
                while (off < len) begin
                    int b;
                    b = (p < len - off) ? p : (len - off);
                    send_cpl(t0, b, off / 4, 1'b0);
                    off += b;
                end
                drain("R5");
            end
        end
        bp_mode = 0;

        // R7/R6/R2: fill pool, finish later reads first, interleaved
        issue(16, 0, t0);
        issue(32, 1, t1);
        issue(8, 2, t2);
        issue(64, 3, t3);
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "req_ready with pool full", 32'(req_ready), 0);
        base_cap = cap_n;
        send_cpl(t3, 16, 0, 1'b0);
        send_cpl(t1, 8, 0, 1'b0);
        send_cpl(t2, 8, 0, 1'b0);
        send_cpl(t3, 16, 4, 1'b0);
        send_cpl(t1, 24, 2, 1'b0);
        send_cpl(t3, 32, 8, 1'b0);
        send_cpl(t0, 4, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R7", "later reads wait for oldest", 32'(out_valid), 0);
        chk(cap_n == base_cap, "R7", "no words before oldest done", 32'(cap_n), 32'(base_cap));
        chk(req_ready == 1'b0, "R3", "finished but undelivered tags held", 32'(req_ready), 0);
        send_cpl(t0, 12, 1, 1'b0);
        drain("R7");

        // R3: reuse a tag released mid-batch
        issue(8, 0, t0);
        issue(8, 1, t1);
        issue(8, 2, t2);
        issue(8, 3, t3);
        base_cap = cap_n;
        send_cpl(t2, 8, 0, 1'b0);
        send_cpl(t0, 8, 0, 1'b0);
        for (int g = 0; g < 50 && cap_n < base_cap + 2; g++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(cap_n == base_cap + 2, "R7", "only oldest delivered", 32'(cap_n), 32'(base_cap + 2));
        chk(req_ready == 1'b1, "R3", "tag released after delivery", 32'(req_ready), 1);
        issue(8, 0, t4);
        send_cpl(t1, 8, 0, 1'b0);
        send_cpl(t4, 4, 0, 1'b0);
        send_cpl(t3, 8, 0, 1'b0);
        send_cpl(t4, 4, 1, 1'b0);
        drain("R3");

        // R9/R10: rejected headers, discarded data
        base_err = err_seen;
        send_cpl(2, 8, 0, 1'b1);
        repeat (2) @(negedge clk);
        chk(err_seen == base_err + 1, "R9", "error for unheld tag", 32'(err_seen), 32'(base_err + 1));
        chk(out_valid == 1'b0, "R9", "no output from unheld tag", 32'(out_valid), 0);
        issue(16, 0, t0);
        send_cpl(t0, 20, 0, 1'b1);
        send_cpl(t0, 0, 0, 1'b1);
        send_cpl(t0, 6, 0, 1'b1);
        send_cpl(t0, 8, 0, 1'b0);
        send_cpl(t0, 12, 0, 1'b1);
        repeat (2) @(negedge clk);
        chk(err_seen == base_err + 5, "R10", "errors for bad sizes", 32'(err_seen), 32'(base_err + 5));
        chk(out_valid == 1'b0, "R10", "read not complete after half", 32'(out_valid), 0);
        send_cpl(t0, 8, 2, 1'b0);
        drain("R10");
        chk(err_seen == base_err + 5, "R10", "no error for good pieces", 32'(err_seen), 32'(base_err + 5));

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule